// File: doc/BRIEF.md
# Programmable FIFO Flag Offset Registers

This block stores the two threshold distances that a synchronous FIFO compares against its fill level to raise its almost-empty and almost-full flags. The FIFO memory, its pointers and the flag comparators sit outside the block. The block only holds the two offsets, lets them be programmed and lets them be read back.

A master reset, sampled on the write clock, does three things. It loads both offsets with one of two defaults, chosen by a select pin. It latches which programming method is in force, either parallel or serial, and that choice holds until the next master reset. It points both access pointers at the almost-empty register.

In parallel mode, each qualifying write-clock edge loads the low bits of the write data bus into one register. The empty offset is loaded first and the full offset next. In serial mode, the two registers form one chain that takes one bit per qualifying write-clock edge. On the read clock, parallel read-back alternates the same way and is available in either mode. When the load control is low, the write and read enables are handed to the FIFO memory instead.

Top module: `ofs_flag_regs`

## Requirements
- R1: During master reset both offsets load 0x07F when `dflt_sel` is 0 or 0x3FF when it is 1, truncated to `OFS_W` bits.
- R2: The programming method is latched from `mode_sel` (0 = parallel, 1 = serial) only while `mrst` is high. Changing `mode_sel` at other times has no effect on which method is accepted.
- R3: In parallel mode, a write-clock edge with `ld` and `wr_en` high loads `wr_data[OFS_W-1:0]` into the empty offset, and the next such edge loads the full offset. The sequence then wraps. Upper data bits are ignored.
- R4: In serial mode, a write-clock edge with `ld` and `ser_en` high shifts `ser_in` into the MSB of the full offset. Every other bit moves one place toward the LSB of the empty offset. After 2·`OFS_W` shifts, the first bit shifted sits in the empty offset's LSB and the last bit shifted sits in the full offset's MSB.
- R5: In serial mode, parallel writes (`ld` and `wr_en` high with `ser_en` low) leave both offsets unchanged.
- R6: In parallel mode, serial shifts (`ld` and `ser_en` high with `wr_en` low) leave both offsets unchanged.
- R7: A read-clock edge with `ld` and `rd_en` high registers onto `rd_data` the empty offset and then, on the next such edge, the full offset. The sequence then wraps. The offset sits in the low bits, and bits above `OFS_W` are zero.
- R8: Parallel read-back works the same way in serial mode.
- R9: With `ld` low, the offsets and `rd_data` do not change. In that case `mem_we` follows `wr_en` and `mem_re` follows `rd_en`. With `ld` high, both strobes are 0.
- R10: Master reset returns both the write pointer and the read pointer to the empty offset, and it clears `rd_data` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write clock; programming and reset sampling |
| rd_clk | input | 1 | Read clock; read-back |
| mrst | input | 1 | Master reset, synchronous, active high |
| dflt_sel | input | 1 | Default select sampled at reset (0: 0x07F, 1: 0x3FF) |
| mode_sel | input | 1 | Method select sampled at reset (0 parallel, 1 serial) |
| ld | input | 1 | Routes enables to the offset registers when high |
| wr_en | input | 1 | Write enable |
| rd_en | input | 1 | Read enable |
| ser_en | input | 1 | Serial shift enable |
| ser_in | input | 1 | Serial data bit |
| wr_data | input | DATA_W | Parallel write data |
| empty_ofs | output | OFS_W | Almost-empty offset |
| full_ofs | output | OFS_W | Almost-full offset |
| rd_data | output | DATA_W | Read-back word |
| mem_we | output | 1 | Write strobe passed to the FIFO memory |
| mem_re | output | 1 | Read strobe passed to the FIFO memory |

## Verification
The bench builds the block with `OFS_W` = 10 and `DATA_W` = 12. With 10 bits, both defaults fit exactly: 0x3FF fills every bit and 0x07F does not. With 10 bits the serial chain is only 20 bits long, so every bit position of both offsets is reached by whole-chain loads of several patterns. The two spare data bits let the bench confirm that upper write bits are dropped and that upper read-back bits are zero. Parallel write-and-read sweeps include all-zero and all-one pairs. Reset is repeated in mid-sequence to show that both pointers return to the empty register.

// File: rtl/ofs_pkg.sv
package ofs_pkg;

  typedef enum logic {
    SEL_EMPTY = 1'b0,
    SEL_FULL  = 1'b1
  } ofs_sel_e;

  typedef enum logic {
    PROG_PAR = 1'b0,
    PROG_SER = 1'b1
  } prog_mode_e;

  // Reset default for both offsets, before truncation to the offset width.
  function automatic logic [31:0] dflt_ofs(input logic hi);
    return hi ? 32'h0000_03FF : 32'h0000_007F;
  endfunction

  // Two-state access pointer: empty -> full -> empty.
  function automatic ofs_sel_e next_sel(input ofs_sel_e s);
    return (s == SEL_EMPTY) ? SEL_FULL : SEL_EMPTY;
  endfunction

endpackage

// File: rtl/ofs_ptr.sv
module ofs_ptr
  import ofs_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     adv,
  output ofs_sel_e sel
);

  ofs_sel_e sel_q;

  always_ff @(posedge clk) begin
    if (rst)      sel_q <= SEL_EMPTY;
    else if (adv) sel_q <= next_sel(sel_q);
  end

  assign sel = sel_q;

endmodule

// File: rtl/ofs_store.sv
module ofs_store
  import ofs_pkg::*;
#(
  parameter int unsigned OFS_W  = 13,
  parameter int unsigned DATA_W = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dflt_hi,
  input  logic              mode_pin,
  input  logic              par_req,
  input  logic              shift_req,
  input  logic              ser_bit,
  input  logic [DATA_W-1:0] wdata,
  output logic [OFS_W-1:0]  empty_q,
  output logic [OFS_W-1:0]  full_q,
  output prog_mode_e        mode,
  output ofs_sel_e          wr_sel,
  output logic              par_wr,
  output logic              ser_shift
);

  localparam int unsigned CHAIN_W = 2 * OFS_W;
  localparam logic [31:0] DFLT_LO32 = dflt_ofs(1'b0);
  localparam logic [31:0] DFLT_HI32 = dflt_ofs(1'b1);

  prog_mode_e         mode_q;
  logic [CHAIN_W-1:0] chain_q;
  logic [OFS_W-1:0]   dflt_val;
  logic [OFS_W-1:0]   wlow;

  assign dflt_val = dflt_hi ? OFS_W'(DFLT_HI32) : OFS_W'(DFLT_LO32);
  assign wlow     = wdata[OFS_W-1:0];

  if (DATA_W > OFS_W) begin : g_hi_bits
    logic unused_hi;
    assign unused_hi = ^wdata[DATA_W-1:OFS_W];
  end

  // Method is captured only while reset is held.
  always_ff @(posedge clk) begin
    if (rst) mode_q <= prog_mode_e'(mode_pin);
  end

  assign par_wr    = !rst && (mode_q == PROG_PAR) && par_req;
  assign ser_shift = !rst && (mode_q == PROG_SER) && shift_req;

  ofs_ptr u_wptr (
    .clk (clk),
    .rst (rst),
    .adv (par_wr),
    .sel (wr_sel)
  );

  // Chain layout: {full, empty}; new bits enter at the full MSB.
  always_ff @(posedge clk) begin
    if (rst) begin
      chain_q <= {dflt_val, dflt_val};
    end else if (ser_shift) begin
      chain_q <= {ser_bit, chain_q[CHAIN_W-1:1]};
    end else if (par_wr) begin
      if (wr_sel == SEL_EMPTY) chain_q[OFS_W-1:0]       <= wlow;
      else                     chain_q[CHAIN_W-1:OFS_W] <= wlow;
    end
  end

  assign empty_q = chain_q[OFS_W-1:0];
  assign full_q  = chain_q[CHAIN_W-1:OFS_W];
  assign mode    = mode_q;

endmodule

// File: rtl/ofs_readback.sv
module ofs_readback
  import ofs_pkg::*;
#(
  parameter int unsigned OFS_W  = 13,
  parameter int unsigned DATA_W = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_req,
  input  logic [OFS_W-1:0]  empty_ofs,
  input  logic [OFS_W-1:0]  full_ofs,
  output logic [DATA_W-1:0] rd_word,
  output ofs_sel_e          rd_sel,
  output logic              rd_fire
);

  localparam int unsigned PAD_W = DATA_W - OFS_W;

  logic [OFS_W-1:0]  pick;
  logic [DATA_W-1:0] word_d;
  logic [DATA_W-1:0] word_q;

  assign rd_fire = !rst && rd_req;
  assign pick    = (rd_sel == SEL_EMPTY) ? empty_ofs : full_ofs;

  if (PAD_W > 0) begin : g_pad
    assign word_d = {{PAD_W{1'b0}}, pick};
  end else begin : g_nopad
    assign word_d = pick;
  end

  ofs_ptr u_rptr (
    .clk (clk),
    .rst (rst),
    .adv (rd_fire),
    .sel (rd_sel)
  );

  always_ff @(posedge clk) begin
    if (rst)          word_q <= '0;
    else if (rd_fire) word_q <= word_d;
  end

  assign rd_word = word_q;

endmodule

// File: rtl/ofs_flag_regs.sv
module ofs_flag_regs
  import ofs_pkg::*;
#(
  parameter int unsigned OFS_W  = 13,
  parameter int unsigned DATA_W = 18
) (
  input  logic              wr_clk,
  input  logic              rd_clk,
  input  logic              mrst,
  input  logic              dflt_sel,
  input  logic              mode_sel,
  input  logic              ld,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic              ser_en,
  input  logic              ser_in,
  input  logic [DATA_W-1:0] wr_data,
  output logic [OFS_W-1:0]  empty_ofs,
  output logic [OFS_W-1:0]  full_ofs,
  output logic [DATA_W-1:0] rd_data,
  output logic              mem_we,
  output logic              mem_re
);

  prog_mode_e ser_mode;
  ofs_sel_e   wr_sel;
  ofs_sel_e   rd_sel;
  logic       par_wr;
  logic       ser_shift;
  logic       rd_fire;

  ofs_store #(.OFS_W(OFS_W), .DATA_W(DATA_W)) u_store (
    .clk       (wr_clk),
    .rst       (mrst),
    .dflt_hi   (dflt_sel),
    .mode_pin  (mode_sel),
    .par_req   (ld && wr_en),
    .shift_req (ld && ser_en),
    .ser_bit   (ser_in),
    .wdata     (wr_data),
    .empty_q   (empty_ofs),
    .full_q    (full_ofs),
    .mode      (ser_mode),
    .wr_sel    (wr_sel),
    .par_wr    (par_wr),
    .ser_shift (ser_shift)
  );

  ofs_readback #(.OFS_W(OFS_W), .DATA_W(DATA_W)) u_rdbk (
    .clk       (rd_clk),
    .rst       (mrst),
    .rd_req    (ld && rd_en),
    .empty_ofs (empty_ofs),
    .full_ofs  (full_ofs),
    .rd_word   (rd_data),
    .rd_sel    (rd_sel),
    .rd_fire   (rd_fire)
  );

  assign mem_we = wr_en && !ld;
  assign mem_re = rd_en && !ld;

endmodule

// File: rtl/ofs_flag_regs_chk.sv
module ofs_flag_regs_chk #(
  parameter int unsigned OFS_W  = 13,
  parameter int unsigned DATA_W = 18
) (
  input logic              wr_clk,
  input logic              rd_clk,
  input logic              mrst,
  input logic              dflt_sel,
  input logic              ld,
  input logic              wr_en,
  input logic              ser_en,
  input logic              ser_in,
  input logic [OFS_W-1:0]  empty_ofs,
  input logic [OFS_W-1:0]  full_ofs,
  input logic [DATA_W-1:0] rd_data,
  input logic              ser_mode,
  input logic              wr_sel,
  input logic              rd_sel,
  input logic              par_wr,
  input logic              ser_shift,
  input logic              rd_fire
);

  localparam logic [31:0] MASK = 32'((64'd1 << OFS_W) - 64'd1);

  bit seen_wr = 1'b0;
  bit seen_rd = 1'b0;
  always_ff @(posedge wr_clk) seen_wr <= 1'b1;
  always_ff @(posedge rd_clk) seen_rd <= 1'b1;

  AST_DEFAULT_LOAD: assert property (@(posedge wr_clk) disable iff (!seen_wr)
    $past(mrst) |-> (32'(empty_ofs) == (ofs_pkg::dflt_ofs($past(dflt_sel)) & MASK)) &&
                    (32'(full_ofs)  == (ofs_pkg::dflt_ofs($past(dflt_sel)) & MASK))); // R1

  AST_MODE_FROZEN: assert property (@(posedge wr_clk) disable iff (mrst || !seen_wr)
    !$past(mrst) |-> $stable(ser_mode)); // R2

  AST_WPTR_STEP: assert property (@(posedge wr_clk) disable iff (mrst)
    par_wr |=> wr_sel != $past(wr_sel)); // R3

  AST_SHIFT_MSB: assert property (@(posedge wr_clk) disable iff (mrst)
    ser_shift |=> full_ofs[OFS_W-1] == $past(ser_in)); // R4

  AST_SER_BLOCKS_PAR: assert property (@(posedge wr_clk) disable iff (mrst)
    (ser_mode && ld && wr_en && !ser_en) |=> $stable(empty_ofs) && $stable(full_ofs)); // R5

  AST_PAR_BLOCKS_SHIFT: assert property (@(posedge wr_clk) disable iff (mrst)
    (!ser_mode && ld && ser_en && !wr_en) |=> $stable(empty_ofs) && $stable(full_ofs)); // R6

  AST_RD_ZERO_PAD: assert property (@(posedge rd_clk) disable iff (mrst)
    (rd_data >> OFS_W) == '0); // R7

  AST_RPTR_STEP: assert property (@(posedge rd_clk) disable iff (mrst)
    rd_fire |=> rd_sel != $past(rd_sel)); // R7

  AST_IDLE_HOLD: assert property (@(posedge wr_clk) disable iff (mrst)
    !ld |=> $stable(empty_ofs) && $stable(full_ofs)); // R9

  AST_WPTR_RESET: assert property (@(posedge wr_clk) disable iff (!seen_wr)
    $past(mrst) |-> !wr_sel); // R10

  AST_RPTR_RESET: assert property (@(posedge rd_clk) disable iff (!seen_rd)
    $past(mrst) |-> !rd_sel && (rd_data == '0)); // R10

endmodule

bind ofs_flag_regs ofs_flag_regs_chk #(.OFS_W(OFS_W), .DATA_W(DATA_W)) u_chk (
  .wr_clk    (wr_clk),
  .rd_clk    (rd_clk),
  .mrst      (mrst),
  .dflt_sel  (dflt_sel),
  .ld        (ld),
  .wr_en     (wr_en),
  .ser_en    (ser_en),
  .ser_in    (ser_in),
  .empty_ofs (empty_ofs),
  .full_ofs  (full_ofs),
  .rd_data   (rd_data),
  .ser_mode  (ser_mode),
  .wr_sel    (wr_sel),
  .rd_sel    (rd_sel),
  .par_wr    (par_wr),
  .ser_shift (ser_shift),
  .rd_fire   (rd_fire)
);

// File: tb/tb_ofs_flag_regs.sv
`timescale 1ns/1ps
module tb_ofs_flag_regs;

  localparam int OW = 10;
  localparam int DW = 12;
  localparam logic [31:0] MASK = (32'd1 << OW) - 32'd1;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic mrst = 1'b1, dflt_sel = 1'b0, mode_sel = 1'b0;
  logic ld = 1'b0, wr_en = 1'b0, rd_en = 1'b0, ser_en = 1'b0, ser_in = 1'b0;
  logic [DW-1:0] wr_data = '0;
  wire  [OW-1:0] empty_ofs, full_ofs;
  wire  [DW-1:0] rd_data;
  wire  mem_we, mem_re;

  int checks = 0;
  int errors = 0;
  logic [2*OW-1:0] model;   // {full, empty}
  logic [31:0] last_rd;

  ofs_flag_regs #(.OFS_W(OW), .DATA_W(DW)) dut (
    .wr_clk(clk), .rd_clk(clk), .mrst(mrst), .dflt_sel(dflt_sel), .mode_sel(mode_sel),
    .ld(ld), .wr_en(wr_en), .rd_en(rd_en), .ser_en(ser_en), .ser_in(ser_in),
    .wr_data(wr_data), .empty_ofs(empty_ofs), .full_ofs(full_ofs), .rd_data(rd_data),
    .mem_we(mem_we), .mem_re(mem_re)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic chk_ofs(input string req);
    chk({req, " empty"}, 32'(empty_ofs), 32'(model[OW-1:0]));
    chk({req, " full"},  32'(full_ofs),  32'(model[2*OW-1:OW]));
  endtask

  task automatic do_reset(input logic hi, input logic ser);
    ld = 0; wr_en = 0; rd_en = 0; ser_en = 0;
    mrst = 1; dflt_sel = hi; mode_sel = ser;
    repeat (2) @(negedge clk);
    mrst = 0; dflt_sel = ~hi;
    model = hi ? {2{OW'(10'h3FF)}} : {2{OW'(10'h07F)}};
    last_rd = 0;
  endtask

  task automatic par_write(input logic [DW-1:0] v);
    ld = 1; wr_en = 1; wr_data = v;
    @(negedge clk);
    ld = 0; wr_en = 0;
  endtask

  task automatic read_one(output logic [31:0] got);
    ld = 1; rd_en = 1;
    #1 chk("R9 mem_re gated by ld", 32'(mem_re), 0);
    @(negedge clk);
    ld = 0; rd_en = 0;
    got = 32'(rd_data);
    last_rd = got;
  endtask

  task automatic shift_bit(input logic b);
    ld = 1; ser_en = 1; ser_in = b;
    @(negedge clk);
    ld = 0; ser_en = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] got;
    logic [OW-1:0] e, f;
    logic [2*OW-1:0] pat;

    // Reset, low default, parallel method
    do_reset(1'b0, 1'b0);
    chk_ofs("R1 low default");
    chk("R10 rd_data cleared", 32'(rd_data), 0);

    // Read-back order and wrap
    for (int k = 0; k < 4; k++) begin
      read_one(got);
      chk("R7 readback order", got, (k % 2 == 0) ? 32'(model[OW-1:0]) : 32'(model[2*OW-1:OW]));
    end

    // Parallel write sweep with junk in upper data bits
    for (int i = 0; i < 18; i++) begin
      e = (i == 16) ? '0 : (i == 17) ? OW'(MASK) : OW'((i * 97 + 3) & MASK);
      f = (i == 16) ? OW'(MASK) : (i == 17) ? '0 : OW'((i * 211 + 600) & MASK);
      par_write({2'(i), e});
      model[OW-1:0] = e;
      chk_ofs("R3 first write hits empty");
      par_write({2'(3 - (i % 4)), f});
      model[2*OW-1:OW] = f;
      chk_ofs("R3 second write hits full");
      read_one(got);
      chk("R7 read empty zero-padded", got, 32'(e));
      read_one(got);
      chk("R7 read full zero-padded", got, 32'(f));
    end

    // Serial shifts ignored in parallel mode
    for (int k = 0; k < 6; k++) shift_bit(k[0]);
    chk_ofs("R6 shift ignored in parallel");

    // ld low: memory strobes, registers untouched
    ld = 0; wr_en = 1; rd_en = 1; wr_data = 12'hABC;
    #1 chk("R9 mem_we follows wr_en", 32'(mem_we), 1);
    chk("R9 mem_re follows rd_en", 32'(mem_re), 1);
    @(negedge clk);
    wr_en = 0; rd_en = 0;
    chk_ofs("R9 ld low holds offsets");
    chk("R9 ld low holds rd_data", 32'(rd_data), last_rd);

    // Method pin change without reset has no effect
    mode_sel = 1;
    for (int k = 0; k < 4; k++) shift_bit(1'b1);
    chk_ofs("R2 serial still refused");
    par_write(12'h0C5);
    model[OW-1:0] = 10'h0C5;
    chk_ofs("R2 parallel still accepted");
    par_write(12'h13A);
    model[2*OW-1:OW] = 10'h13A;
    chk_ofs("R2 parallel still accepted full");

    // Pointer reset: leave both pointers on full, then reset
    par_write(12'h011);
    read_one(got);
    do_reset(1'b0, 1'b0);
    par_write(12'h2A5);
    model[OW-1:0] = 10'h2A5;
    chk_ofs("R10 write pointer back at empty");
    read_one(got);
    chk("R10 read pointer back at empty", got, 32'h2A5);

    // Reset, high default, serial method
    do_reset(1'b1, 1'b1);
    chk_ofs("R1 high default");
    read_one(got);
    chk("R8 readback in serial mode empty", got, 32'h3FF);
    read_one(got);
    chk("R8 readback in serial mode full", got, 32'h3FF);

    // Serial chain loads
    for (int p = 0; p < 6; p++) begin
      pat = (p == 0) ? 20'h00001 : (p == 1) ? 20'h80000 : (p == 2) ? 20'hFFFFF :
            (p == 3) ? 20'h00000 : 20'((p * 32'h2F3A5 + 32'h1234B) & 32'hFFFFF);
      for (int k = 0; k < 2 * OW; k++) begin
        shift_bit(pat[k]);
        model = {pat[k], model[2*OW-1:1]};
        chk("R4 shifted bit lands at full MSB", 32'(full_ofs[OW-1]), 32'(pat[k]));
      end
      chk("R4 empty after full chain", 32'(empty_ofs), 32'(pat[OW-1:0]));
      chk("R4 full after full chain", 32'(full_ofs), 32'(pat[2*OW-1:OW]));
      read_one(got);
      chk("R8 serial readback empty", got, 32'(pat[OW-1:0]));
      read_one(got);
      chk("R8 serial readback full", got, 32'(pat[2*OW-1:OW]));
    end

    // Parallel writes ignored in serial mode
    par_write(12'h155);
    par_write(12'h2AA);
    chk_ofs("R5 parallel ignored in serial");

    // Method pin change without reset: still serial
    mode_sel = 0;
    par_write(12'h0F0);
    chk_ofs("R2 parallel still refused");
    shift_bit(1'b0);
    model = {1'b0, model[2*OW-1:1]};
    chk_ofs("R2 serial still accepted");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule